// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block drives an external analog-to-digital converter from a table of 64 conversion commands. The table is shared by two scan queues. Queue 1 always starts at entry 0. Queue 2 starts at an entry chosen by a programmable split pointer. When a queue's trigger event arrives, the sequencer steps through that queue's commands in order. For each command it presents the channel, sample time and buffer-bypass request to the converter and waits for the converter's result. Each 10-bit result is stored in the result slot whose index matches the command.

A scan stops in one of three ways: at a command whose channel field holds the end-of-queue code, at the last entry of the queue's region, or after a command carrying the pause flag. After a pause, the queue waits for its next trigger and then continues with the entry that follows. Software reads results through a combinational read port in one of three 16-bit alignments. Each queue reports active, paused and complete through its own status outputs.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset all status outputs are low, `conv_start` is low and every result slot reads as zero.
- R2: A command word holds the channel in bits [5:0], the sample time in bits [7:6], the buffer bypass flag in bit 8 and the pause flag in bit 9. `conv_chan`, `conv_ist` and `conv_byp` carry these fields while `conv_start` is high.
- R3: The result returned for the command at index i is written to result slot i and to no other slot.
- R4: Queue 1 begins at index 0. It ends at the index just below the split pointer, or at index 63 when the split pointer (7 bits) is 64 or more.
- R5: Queue 2 begins at the split pointer and runs to index 63. With the split pointer at 0, queue 2 owns the whole table and a queue 1 trigger completes at once with no conversion.
- R6: A channel field of 63 is the end-of-queue code. No conversion is issued for it, the queue is marked complete, and its result slot is left untouched.
- R7: After a command whose pause flag is set has been converted, the queue becomes paused. Its next trigger resumes at the following index. A pause on the last entry of the region completes the queue instead.
- R8: Each queue has a 2-bit mode: 00 disabled, bit 0 enables the software trigger `sw_trig`, bit 1 enables the external trigger `ext_trig`. A trigger whose kind is not enabled has no effect.
- R9: Only one conversion is outstanding at a time. `conv_start` lasts one cycle and the next start follows only after `conv_done`. A `conv_done` with no conversion outstanding changes no result.
- R10: Only one queue runs at a time. A trigger that arrives while a queue runs is dropped. If both queues trigger in the same cycle, queue 1 runs and the queue 2 trigger is dropped.
- R11: A mode write to a queue while that queue is active is ignored.
- R12: `rd_fmt` 00 returns the result right-justified with zeros above it. 01 returns it left-justified with zeros in bits [5:0]. 1x returns it left-justified with bit 15 inverted as a sign, again with zeros in bits [5:0].
- R13: Per queue, exactly one of active, paused and complete may be high. Active holds from trigger acceptance to the end of the scan. `conv_start` occurs only while some queue is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command table write enable |
| cmd_addr | input | 6 | Command table write index |
| cmd_wdata | input | 10 | Command word to write |
| split_we | input | 1 | Split pointer write enable |
| split_wdata | input | 7 | New queue 2 begin index |
| mode_we | input | 2 | Per-queue mode write enable |
| mode_wdata | input | 2 | Mode value to write |
| sw_trig | input | 2 | Software trigger pulse per queue |
| ext_trig | input | 2 | External trigger pulse per queue |
| conv_start | output | 1 | Conversion request strobe |
| conv_chan | output | 6 | Requested channel |
| conv_ist | output | 2 | Requested sample time |
| conv_byp | output | 1 | Requested buffer bypass |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | 10 | Converted value |
| rd_addr | input | 6 | Result slot to read |
| rd_fmt | input | 2 | Read alignment select |
| rd_data | output | 16 | Formatted result |
| q_active | output | 2 | Queue running, per queue |
| q_paused | output | 2 | Queue paused, per queue |
| q_done | output | 2 | Queue complete, per queue |

## Verification
Two things can compete for the sequencer in a single cycle: a trigger for queue 1 and a trigger for queue 2, and a trigger for one queue while the other is running. The bench fires both software and external triggers on the same clock edge. It also fires a queue 2 trigger in the middle of a queue 1 scan, and writes a mode change to the running queue at the same time. The scoreboard holds only the conversions that queue 1 should issue, so any conversion from queue 2 shows up as an unexpected item. The status outputs and a later re-trigger confirm that the mode write was ignored.

// File: rtl/adc_queue_seq.sv
`timescale 1ns/1ps
module adc_queue_seq #(
  parameter int ENTRIES = 64,
  parameter int RES_W   = 10,
  parameter int CH_W    = 6,
  parameter int IST_W   = 2,
  parameter int OUT_W   = 16,
  localparam int AW     = $clog2(ENTRIES),
  localparam int PW     = AW + 1,
  localparam int CW     = CH_W + IST_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [CW-1:0]    cmd_wdata,
  input  logic             split_we,
  input  logic [PW-1:0]    split_wdata,
  input  logic [1:0]       mode_we,
  input  logic [1:0]       mode_wdata,
  input  logic [1:0]       sw_trig,
  input  logic [1:0]       ext_trig,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic [IST_W-1:0] conv_ist,
  output logic             conv_byp,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic [AW-1:0]    rd_addr,
  input  logic [1:0]       rd_fmt,
  output logic [OUT_W-1:0] rd_data,
  output logic [1:0]       q_active,
  output logic [1:0]       q_paused,
  output logic [1:0]       q_done
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_PAUSE = 2'd2, ST_DONE = 2'd3;
  localparam logic [PW-1:0] TOP = PW'(ENTRIES);
  localparam int PAD = OUT_W - RES_W;

  logic [CW-1:0]    cmd_mem [ENTRIES];
  logic [RES_W-1:0] res_mem [ENTRIES];
  logic [1:0]       qst  [2];
  logic [1:0]       mode [2];
  logic [PW-1:0]    ptr  [2];
  logic [PW-1:0]    split, idx, lim, nxt;
  logic             cur, waiting, busy, in_range, eoq;
  logic [1:0]       trig, go;
  logic [CW-1:0]    cw;
  logic [RES_W-1:0] rv;

  assign busy     = (qst[0] == ST_RUN) || (qst[1] == ST_RUN);
  assign lim      = cur ? TOP : ((split < TOP) ? split : TOP);
  assign cw       = cmd_mem[idx[AW-1:0]];
  assign in_range = idx < lim;
  assign eoq      = &cw[CH_W-1:0];
  assign nxt      = idx + 1'b1;

  always_comb begin
    for (int q = 0; q < 2; q++)
      trig[q] = (mode[q][0] & sw_trig[q]) | (mode[q][1] & ext_trig[q]);
    go[0] = !busy & trig[0];
    go[1] = !busy & trig[1] & !trig[0];
  end

  assign conv_start = busy & !waiting & in_range & !eoq;
  assign conv_chan  = cw[CH_W-1:0];
  assign conv_ist   = cw[CH_W +: IST_W];
  assign conv_byp   = cw[CH_W+IST_W];

  always_ff @(posedge clk)
    if (cmd_we) cmd_mem[cmd_addr] <= cmd_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) res_mem[i] <= '0;
      for (int q = 0; q < 2; q++) begin
        qst[q]  <= ST_IDLE;
        mode[q] <= 2'b00;
        ptr[q]  <= '0;
      end
      split   <= TOP;
      idx     <= '0;
      cur     <= 1'b0;
      waiting <= 1'b0;
    end else begin
      if (split_we) split <= split_wdata;
      for (int q = 0; q < 2; q++)
        if (mode_we[q] && qst[q] != ST_RUN) mode[q] <= mode_wdata;
      if (|go) begin
        qst[go[1]] <= ST_RUN;
        cur        <= go[1];
        waiting    <= 1'b0;
        idx        <= (qst[go[1]] == ST_PAUSE) ? ptr[go[1]] : (go[1] ? split : '0);
      end else if (busy) begin
        if (!waiting) begin
          if (!in_range || eoq) qst[cur] <= ST_DONE;
          else waiting <= 1'b1;
        end else if (conv_done) begin
          res_mem[idx[AW-1:0]] <= conv_result;
          if (nxt >= lim) qst[cur] <= ST_DONE;
          else if (cw[CW-1]) begin
            qst[cur] <= ST_PAUSE;
            ptr[cur] <= nxt;
          end else begin
            idx     <= nxt;
            waiting <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_stat
    assign q_active[g] = qst[g] == ST_RUN;
    assign q_paused[g] = qst[g] == ST_PAUSE;
    assign q_done[g]   = qst[g] == ST_DONE;
  end

  assign rv = res_mem[rd_addr];
  always_comb
    case (rd_fmt)
      2'b00:   rd_data = {{PAD{1'b0}}, rv};
      2'b01:   rd_data = {rv, {PAD{1'b0}}};
      default: rd_data = {~rv[RES_W-1], rv[RES_W-2:0], {PAD{1'b0}}};
    endcase
endmodule

module adc_queue_seq_chk #(
  parameter int CH_W  = 6,
  parameter int OUT_W = 16,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic [CH_W-1:0]  conv_chan,
  input logic [1:0]       rd_fmt,
  input logic [OUT_W-1:0] rd_data,
  input logic [1:0]       q_active,
  input logic [1:0]       q_paused,
  input logic [1:0]       q_done
);
  localparam int PAD = OUT_W - RES_W;
  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) conv_start |-> q_active != 2'b00); // R13
  AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_active)); // R10
  AST_STATUS_EXCL0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({q_active[0], q_paused[0], q_done[0]})); // R13
  AST_STATUS_EXCL1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({q_active[1], q_paused[1], q_done[1]})); // R13
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start); // R9
  AST_NO_EOQ_START: assert property (@(posedge clk) disable iff (!rst_n) conv_start |-> conv_chan != {CH_W{1'b1}}); // R6
  AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_fmt != 2'b00 |-> rd_data[PAD-1:0] == '0); // R12
  AST_RIGHT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_fmt == 2'b00 |-> rd_data[OUT_W-1:RES_W] == '0); // R12
endmodule

bind adc_queue_seq adc_queue_seq_chk #(.CH_W(CH_W), .OUT_W(OUT_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
  .rd_fmt(rd_fmt), .rd_data(rd_data), .q_active(q_active), .q_paused(q_paused), .q_done(q_done)
);

// File: tb/adc_queue_seq_test.sv
`timescale 1ns/1ps
module adc_queue_seq_test;
  logic clk = 0, rst_n = 0;
  logic cmd_we = 0; logic [5:0] cmd_addr = 0; logic [9:0] cmd_wdata = 0;
  logic split_we = 0; logic [6:0] split_wdata = 0;
  logic [1:0] mode_we = 0, mode_wdata = 0, sw_trig = 0, ext_trig = 0;
  logic conv_start, conv_byp; logic [5:0] conv_chan; logic [1:0] conv_ist;
  logic conv_done = 0; logic [9:0] conv_result = 0;
  logic [5:0] rd_addr = 0; logic [1:0] rd_fmt = 0; logic [15:0] rd_data;
  logic [1:0] q_active, q_paused, q_done;

  always #2.5 clk = ~clk;

  adc_queue_seq uut (.*);

  int checks = 0, fails = 0;
  logic [9:0] cmd_m [64];
  logic [9:0] exp_res [64];
  logic [8:0] expq [$];
  int mst [2];
  int mptr [2];
  int split_m = 64;

  function automatic logic [9:0] resf(logic [8:0] w);
    return 10'((w[5:0] * 11 + w[7:6] * 97 + w[8] * 300 + 3) % 1024);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model
  initial forever begin
    @(negedge clk);
    conv_done = 0;
    if (conv_start) begin
      logic [8:0] w;
      w = {conv_byp, conv_ist, conv_chan};
      repeat (3) @(negedge clk);
      conv_result = resf(w);
      conv_done = 1;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      if (expq.size() == 0) chk(0, "R10", "unexpected conversion chan", int'(conv_chan), -1);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({conv_byp, conv_ist, conv_chan} == e, "R2", "conversion request", int'({conv_byp, conv_ist, conv_chan}), int'(e));
      end
    end
  end

  task automatic wr_cmd(int a, logic [9:0] d);
    @(negedge clk); cmd_we = 1; cmd_addr = 6'(a); cmd_wdata = d; cmd_m[a] = d;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic set_split(int v);
    @(negedge clk); split_we = 1; split_wdata = 7'(v); split_m = v;
    @(negedge clk); split_we = 0;
  endtask

  task automatic set_mode(int q, logic [1:0] m);
    @(negedge clk); mode_we[q] = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic predict(int q);
    int idx, lim;
    lim = (q == 1) ? 64 : (split_m < 64 ? split_m : 64);
    idx = (mst[q] == 2) ? mptr[q] : (q == 1 ? split_m : 0);
    mst[q] = 3;
    while (1) begin
      if (idx >= lim || cmd_m[idx][5:0] == 6'd63) break;
      expq.push_back(cmd_m[idx][8:0]);
      exp_res[idx] = resf(cmd_m[idx][8:0]);
      if (idx + 1 >= lim) break;
      if (cmd_m[idx][9]) begin mst[q] = 2; mptr[q] = idx + 1; break; end
      idx++;
    end
  endtask

  task automatic fire(logic [1:0] sw, logic [1:0] ext);
    @(negedge clk); sw_trig = sw; ext_trig = ext;
    @(negedge clk); sw_trig = 0; ext_trig = 0;
  endtask

  task automatic wait_idle();
    while (q_active != 0) @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R3", "missing conversions", expq.size(), 0);
  endtask

  task automatic chk_status(int q, string req);
    chk(q_paused[q] == (mst[q] == 2), req, $sformatf("q%0d paused", q), q_paused[q], mst[q] == 2);
    chk(q_done[q] == (mst[q] == 3), req, $sformatf("q%0d complete", q), q_done[q], mst[q] == 3);
  endtask

  task automatic chk_slot(int i, logic [1:0] f, string req);
    logic [15:0] e;
    @(negedge clk); rd_addr = 6'(i); rd_fmt = f; #1;
    case (f)
      2'b00: e = {6'b0, exp_res[i]};
      2'b01: e = {exp_res[i], 6'b0};
      default: e = {~exp_res[i][9], exp_res[i][8:0], 6'b0};
    endcase
    chk(rd_data == e, req, $sformatf("slot %0d fmt %0d", i, f), rd_data, e);
  endtask

  task automatic readback_all(string req);
    for (int i = 0; i < 64; i++) chk_slot(i, 2'b00, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_res[i] = 0;
    mst[0] = 0; mst[1] = 0; mptr[0] = 0; mptr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(q_active == 0 && q_paused == 0 && q_done == 0, "R1", "status after reset", {q_active, q_paused, q_done}, 0);
    chk(conv_start == 0, "R1", "conv_start after reset", conv_start, 0);
    chk_slot(5, 2'b00, "R1");
    chk_slot(63, 2'b01, "R1");

    for (int i = 0; i < 64; i++) wr_cmd(i, {1'b0, 1'(i), 2'(i % 4), 6'(i % 62)});

    // R4 whole table to queue 1, R6 end-of-queue at 6
    set_split(64);
    wr_cmd(6, {4'b0000, 6'd63});
    set_mode(0, 2'b01);
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R6");
    chk_slot(6, 2'b00, "R6");
    chk_slot(3, 2'b00, "R12"); chk_slot(3, 2'b01, "R12"); chk_slot(3, 2'b10, "R12");
    chk_slot(5, 2'b11, "R12");

    // R7 pause and resume
    wr_cmd(2, cmd_m[2] | 10'h200);
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R7");
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R7");
    wr_cmd(2, cmd_m[2] & 10'h1FF);

    // R4/R5 split at 4; R8 trigger kinds
    set_split(4);
    set_mode(1, 2'b10);
    fire(2'b10, 2'b01); wait_idle();
    chk(q_active == 0 && q_done[1] == 0, "R8", "ignored trigger kinds", {q_active, q_done}, 0);
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R4");
    predict(1); fire(2'b00, 2'b10); wait_idle();
    chk_status(1, "R5");
    readback_all("R3");

    // R10 same-cycle triggers, R11 mode write while active
    predict(0);
    @(negedge clk); sw_trig = 2'b01; ext_trig = 2'b10;
    @(negedge clk); sw_trig = 0; ext_trig = 0;
    @(negedge clk); ext_trig = 2'b10; mode_we = 2'b01; mode_wdata = 2'b00;
    @(negedge clk); ext_trig = 0; mode_we = 0;
    wait_idle();
    chk_status(0, "R10");
    chk_status(1, "R10");
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R11");

    // R7 pause on last entry of queue 1 completes it
    wr_cmd(3, cmd_m[3] | 10'h200);
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk(mst[0] == 3, "R7", "model complete", mst[0], 3);
    chk_status(0, "R7");
    wr_cmd(3, cmd_m[3] & 10'h1FF);

    // R9 spurious done while idle
    @(negedge clk); conv_result = 10'h155; conv_done = 1;
    @(negedge clk); conv_done = 0;
    readback_all("R9");

    // R5 whole table to queue 2
    wr_cmd(6, {1'b0, 1'b0, 2'd2, 6'd6});
    set_mode(0, 2'b00);
    set_split(0);
    fire(2'b01, 2'b00); wait_idle();
    chk(q_done[0] == 1 && q_active == 0, "R8", "disabled queue 1", {q_done[0], q_active}, 4);
    predict(1); fire(2'b00, 2'b10); wait_idle();
    chk_status(1, "R5");
    set_mode(0, 2'b01);
    predict(0); fire(2'b01, 2'b00); wait_idle();
    chk_status(0, "R5");
    readback_all("R3");
    for (int i = 0; i < 64; i += 9) chk_slot(i, 2'b10, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule